// File: doc/BRIEF.md
# Bus Ownership Semaphore

This block settles which of two agents, the host processor or an embedded microcontroller, may drive a shared SMBus. Both agents see the same control byte at a fixed register offset. An agent asks for the bus by writing a one to the request bit. It then reads the byte back: a set request bit means the bus is its own, and a clear bit means it must try again later. The bus is given up by writing a one to a separate release bit.

Only one agent holds the bus at a time. The block drives a grant line for each agent, high while that agent owns the bus. The bus engine uses these lines to decide whose transaction may start. Both register views decode the same layout. The request bit position and the release bit position are parameters, as are the register offset and the address and data widths.

Top module: `smsem_top`

## Requirements
- R1: After reset neither agent owns the bus. Both grant outputs are low and both views read 0x00 at the semaphore offset.
- R2: A write at offset 8 with bit 4 (value 0x10) set, made while the bus is free, gives that agent the bus from the next cycle on. Its grant goes high and its view reads bit 4 as 1, so 0x10 is read back.
- R3: A request from one agent while the other holds the bus has no effect. The requester keeps reading bit 4 as 0, and the holder keeps its grant.
- R4: When both agents request in the same cycle while the bus is free, the microcontroller receives the bus.
- R5: A write at offset 8 with bit 5 (value 0x20) set, made by the current owner, frees the bus from the next cycle on.
- R6: A release write from an agent that does not own the bus is ignored, and ownership stays where it was.
- R7: Bit 5 and all bits other than bit 4 always read as 0. Any address other than offset 8 reads 0x00.
- R8: Writes to addresses other than offset 8 change nothing.
- R9: The two grant outputs are never high together.
- R10: A request made in the same cycle as the owner's release is refused, and the bus is free in the following cycle.
- R11: One write carrying both bits 4 and 5 acts as a release if the writer owns the bus. Otherwise it acts as a request.
- R12: Ownership changes only in the cycle after a semaphore write. Without such a write, both grants hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | ADDR_W | Host register address (write and read) |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data for host_addr |
| mcu_wr | input | 1 | Microcontroller register write strobe |
| mcu_addr | input | ADDR_W | Microcontroller register address |
| mcu_wdata | input | DATA_W | Microcontroller write data |
| mcu_rdata | output | DATA_W | Microcontroller read data for mcu_addr |
| host_grant | output | 1 | High while the host owns the bus |
| mcu_grant | output | 1 | High while the microcontroller owns the bus |

## Verification
The bench builds the block with its default parameters: a 4-bit address, an 8-bit data byte, the semaphore at offset 8, the request bit at position 4 and the release bit at position 5. The 4-bit address lets the bench aim writes and reads at neighbouring offsets such as 7 and 3, which shows that only offset 8 is decoded. Writes of 0x30 and 0xFF reach the case where one write carries both bits. The cycle-by-cycle model covers same-cycle collisions between the two agents, both for a free bus and during a release.

// File: rtl/smsem_pkg.sv
package smsem_pkg;

    localparam int NUM_AGENTS = 2;
    localparam int AGENT_HOST = 0;
    localparam int AGENT_MCU  = 1;

    typedef enum logic [1:0] {
        OWNER_NONE = 2'd0,
        OWNER_HOST = 2'd1,
        OWNER_MCU  = 2'd2
    } owner_e;

    typedef struct packed {
        logic req;
        logic rel;
    } sem_cmd_t;

    function automatic owner_e agent_owner(input int idx);
        return (idx == AGENT_MCU) ? OWNER_MCU : OWNER_HOST;
    endfunction

endpackage

// File: rtl/smsem_port.sv
module smsem_port
    import smsem_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int OFFSET  = 8,
    parameter int REQ_BIT = 4,
    parameter int REL_BIT = 5
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              owned,
    output sem_cmd_t          cmd,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(OFFSET);

    logic hit;
    logic unused_wbits;

    assign hit          = (addr == HIT_ADDR);
    assign unused_wbits = ^wdata;

    always_comb begin
        cmd.req = wr && hit && wdata[REQ_BIT];
        cmd.rel = wr && hit && wdata[REL_BIT];
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[REQ_BIT] = owned;
        end
    end
endmodule

// File: rtl/smsem_arbiter.sv
module smsem_arbiter
    import smsem_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sem_cmd_t cmd   [NUM_AGENTS],
    output logic     grant [NUM_AGENTS]
);
    owner_e owner_q;
    owner_e owner_d;

    always_comb begin
        owner_d = owner_q;
        unique case (owner_q)
            OWNER_HOST: if (cmd[AGENT_HOST].rel) owner_d = OWNER_NONE;
            OWNER_MCU:  if (cmd[AGENT_MCU].rel)  owner_d = OWNER_NONE;
            default: begin
                if (cmd[AGENT_MCU].req)       owner_d = OWNER_MCU;
                else if (cmd[AGENT_HOST].req) owner_d = OWNER_HOST;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) owner_q <= OWNER_NONE;
        else     owner_q <= owner_d;
    end

    for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_grant
        assign grant[g] = (owner_q == agent_owner(g));
    end
endmodule

// File: rtl/smsem_top.sv
module smsem_top
    import smsem_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int OFFSET  = 8,
    parameter int REQ_BIT = 4,
    parameter int REL_BIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              mcu_wr,
    input  logic [ADDR_W-1:0] mcu_addr,
    input  logic [DATA_W-1:0] mcu_wdata,
    output logic [DATA_W-1:0] mcu_rdata,
    output logic              host_grant,
    output logic              mcu_grant
);
    logic              wr_a    [NUM_AGENTS];
    logic [ADDR_W-1:0] addr_a  [NUM_AGENTS];
    logic [DATA_W-1:0] wdata_a [NUM_AGENTS];
    logic [DATA_W-1:0] rdata_a [NUM_AGENTS];
    sem_cmd_t          cmd_a   [NUM_AGENTS];
    logic              grant_a [NUM_AGENTS];

    assign wr_a[AGENT_HOST]    = host_wr;
    assign addr_a[AGENT_HOST]  = host_addr;
    assign wdata_a[AGENT_HOST] = host_wdata;
    assign wr_a[AGENT_MCU]     = mcu_wr;
    assign addr_a[AGENT_MCU]   = mcu_addr;
    assign wdata_a[AGENT_MCU]  = mcu_wdata;

    for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_port
        smsem_port #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .OFFSET (OFFSET),
            .REQ_BIT(REQ_BIT),
            .REL_BIT(REL_BIT)
        ) u_port (
            .wr   (wr_a[g]),
            .addr (addr_a[g]),
            .wdata(wdata_a[g]),
            .owned(grant_a[g]),
            .cmd  (cmd_a[g]),
            .rdata(rdata_a[g])
        );
    end

    smsem_arbiter u_arb (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd_a),
        .grant(grant_a)
    );

    assign host_rdata = rdata_a[AGENT_HOST];
    assign mcu_rdata  = rdata_a[AGENT_MCU];
    assign host_grant = grant_a[AGENT_HOST];
    assign mcu_grant  = grant_a[AGENT_MCU];
endmodule

// File: rtl/smsem_chk.sv
module smsem_chk #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int OFFSET  = 8,
    parameter int REQ_BIT = 4,
    parameter int REL_BIT = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic              mcu_wr,
    input logic [ADDR_W-1:0] mcu_addr,
    input logic [DATA_W-1:0] mcu_wdata,
    input logic [DATA_W-1:0] mcu_rdata,
    input logic              host_grant,
    input logic              mcu_grant
);
    logic h_hit, m_hit, h_req, h_rel, m_req, m_rel;
    assign h_hit = host_wr && (host_addr == ADDR_W'(OFFSET));
    assign m_hit = mcu_wr  && (mcu_addr  == ADDR_W'(OFFSET));
    assign h_req = h_hit && host_wdata[REQ_BIT];
    assign h_rel = h_hit && host_wdata[REL_BIT];
    assign m_req = m_hit && mcu_wdata[REQ_BIT];
    assign m_rel = m_hit && mcu_wdata[REL_BIT];

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!host_grant && !mcu_grant));

    assert_host_grant_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(host_grant) |-> $past(h_req));

    assert_holder_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (mcu_grant && !m_rel) |=> mcu_grant);

    assert_tie_to_mcu_R4: assert property (@(posedge clk) disable iff (rst)
        (!host_grant && !mcu_grant && h_req && m_req) |=> mcu_grant);

    assert_host_release_R5: assert property (@(posedge clk) disable iff (rst)
        (host_grant && h_rel) |=> !host_grant);

    assert_rel_bit_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (host_rdata[REL_BIT] == 1'b0) && (mcu_rdata[REL_BIT] == 1'b0));

    assert_one_owner_R9: assert property (@(posedge clk) disable iff (rst)
        !(host_grant && mcu_grant));

    assert_no_spurious_change_R12: assert property (@(posedge clk) disable iff (rst)
        (!h_hit && !m_hit) |=> $stable({host_grant, mcu_grant}));
endmodule

bind smsem_top smsem_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OFFSET (OFFSET),
    .REQ_BIT(REQ_BIT),
    .REL_BIT(REL_BIT)
) u_chk (.*);

// File: tb/smsem_top_tb.sv
module smsem_top_tb;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              host_wr = 1'b0;
    logic [ADDR_W-1:0] host_addr = 4'd8;
    logic [DATA_W-1:0] host_wdata = '0;
    logic [DATA_W-1:0] host_rdata;
    logic              mcu_wr = 1'b0;
    logic [ADDR_W-1:0] mcu_addr = 4'd8;
    logic [DATA_W-1:0] mcu_wdata = '0;
    logic [DATA_W-1:0] mcu_rdata;
    logic              host_grant;
    logic              mcu_grant;

    int checks = 0;
    int errors = 0;
    int owner  = 0; // 0 free, 1 host, 2 mcu
    bit done   = 1'b0;

    always #4 clk = ~clk;

    smsem_top u_dut (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .mcu_wr(mcu_wr), .mcu_addr(mcu_addr), .mcu_wdata(mcu_wdata),
        .mcu_rdata(mcu_rdata),
        .host_grant(host_grant), .mcu_grant(mcu_grant)
    );

    function automatic logic [7:0] view(input int who, input logic [3:0] a);
        if (a != 4'd8) return 8'h00;
        return (owner == who) ? 8'h10 : 8'h00;
    endfunction

    task automatic expect_eq(input string tag, input string what,
                             input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        expect_eq(tag, "host_grant", host_grant, owner == 1);
        expect_eq(tag, "mcu_grant",  mcu_grant,  owner == 2);
        expect_eq(tag, "host_rdata", host_rdata, view(1, host_addr));
        expect_eq(tag, "mcu_rdata",  mcu_rdata,  view(2, mcu_addr));
    endtask

    // Behavioural model of ownership, applied after each rising edge.
    task automatic model_step();
        bit hq, hl, mq, ml;
        hq = host_wr && host_addr == 4'd8 && host_wdata[4];
        hl = host_wr && host_addr == 4'd8 && host_wdata[5];
        mq = mcu_wr  && mcu_addr  == 4'd8 && mcu_wdata[4];
        ml = mcu_wr  && mcu_addr  == 4'd8 && mcu_wdata[5];
        if (rst)                    owner = 0;
        else if (owner == 1)        begin if (hl) owner = 0; end
        else if (owner == 2)        begin if (ml) owner = 0; end
        else if (mq)                owner = 2;
        else if (hq)                owner = 1;
    endtask

    // Called at a falling edge; drives one cycle of writes and checks after it.
    task automatic step(input bit hw, input logic [3:0] ha, input logic [7:0] hd,
                        input bit mw, input logic [3:0] ma, input logic [7:0] md,
                        input string tag);
        host_wr = hw; host_addr = ha; host_wdata = hd;
        mcu_wr  = mw; mcu_addr  = ma; mcu_wdata  = md;
        @(posedge clk);
        model_step();
        @(negedge clk);
        host_wr = 1'b0; mcu_wr = 1'b0;
        host_addr = 4'd8; mcu_addr = 4'd8;
        #1;
        compare_all(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 4'd8, 8'h00, 0, 4'd8, 8'h00, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        compare_all("R1");                              // reset state
        step(1, 4'd8, 8'h10, 0, 4'd8, 8'h00, "R2");     // host takes free bus
        expect_eq("R2", "host read 0x10", host_rdata, 8'h10);
        step(0, 4'd8, 8'h00, 1, 4'd8, 8'h10, "R3");     // mcu blocked
        step(0, 4'd8, 8'h00, 1, 4'd8, 8'h20, "R6");     // non-owner release
        step(1, 4'd7, 8'h20, 0, 4'd8, 8'h00, "R8");     // wrong offset release
        step(1, 4'd7, 8'h10, 1, 4'd9, 8'h10, "R8");
        idle("R12");
        idle("R12");
        step(1, 4'd8, 8'h20, 0, 4'd8, 8'h00, "R5");     // host releases
        step(0, 4'd8, 8'h00, 1, 4'd8, 8'h10, "R2");     // mcu takes
        step(1, 4'd8, 8'h10, 0, 4'd8, 8'h00, "R3");     // host blocked
        expect_eq("R3", "host read 0x00", host_rdata, 8'h00);
        step(1, 4'd8, 8'h20, 0, 4'd8, 8'h00, "R6");     // host non-owner release
        step(1, 4'd8, 8'h10, 1, 4'd8, 8'h20, "R10");    // release+request collide
        expect_eq("R10", "bus free", {host_grant, mcu_grant}, 0);
        step(1, 4'd8, 8'h10, 1, 4'd8, 8'h10, "R4");     // tie -> mcu
        expect_eq("R4", "mcu wins", mcu_grant, 1);
        step(0, 4'd8, 8'h00, 1, 4'd8, 8'h30, "R11");    // owner both bits -> release
        step(1, 4'd8, 8'h30, 0, 4'd8, 8'h00, "R11");    // free both bits -> request
        expect_eq("R11", "host owns", host_grant, 1);
        step(0, 4'd8, 8'h00, 1, 4'd8, 8'hFF, "R6");     // mcu both bits, non-owner
        // read-back layout checks at other offsets
        host_addr = 4'd3; mcu_addr = 4'd7; #1;
        expect_eq("R7", "host other addr", host_rdata, 8'h00);
        expect_eq("R7", "mcu other addr",  mcu_rdata,  8'h00);
        host_addr = 4'd8; mcu_addr = 4'd8; #1;
        expect_eq("R7", "bit5 clear", host_rdata[5], 0);
        step(1, 4'd8, 8'hFF, 0, 4'd8, 8'h00, "R11");    // owner 0xFF releases
        step(1, 4'd8, 8'hEF, 0, 4'd8, 8'h00, "R7");     // no req bit: stays free
        idle("R12");
        // reset while owned
        step(1, 4'd8, 8'h10, 0, 4'd8, 8'h00, "R2");
        rst = 1'b1;
        step(0, 4'd8, 8'h00, 0, 4'd8, 8'h00, "R1");
        rst = 1'b0;
        idle("R1");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule